// File: doc/BRIEF.md
# Conditional Execute and Writeback Controller

This block is the control stage in front of a 32-bit register datapath. It takes one instruction word at a time and splits it into fields. It tests the instruction's condition against the zero and carry flags that it holds. It then decides whether a result is written back and whether each flag is updated. It also tells the datapath whether the source operand is a register value or an immediate. A small arithmetic unit (move, add, subtract, AND) sits inside so that results and flags can be exercised.

Issuing works as follows. While the block is idle, the datapath presents a word on the issue port. The block then occupies four clocks. During that time it drives the register addresses, and the datapath returns the destination and source register contents. All results are committed together in the fourth clock, whether the instruction executes or is skipped. An issue offered while an instruction is in flight is dropped.

Top module: `cexec_ctrl`

## Requirements
- R1: Field positions from bit 31 down are: opcode [31:26], zero-update bit [25], carry-update bit [24], result-write bit [23], immediate bit [22], condition [21:18], destination [17:9], source [8:0]. `dst_addr` and `src_addr` show the destination and source fields while busy.
- R2: The condition passes when bit index {C,Z} of the 4-bit condition field is 1, where the index is carry*2 + zero. Code 0000 therefore never passes and code 1111 always passes.
- R3: When the condition fails, no register write happens, no flag changes, and the instruction still takes four clocks.
- R4: When the immediate bit is set, the source operand is the 9-bit source field zero-extended to 32 bits and `op_sel_imm` is 1. Otherwise the operand is `src_rdata` and `op_sel_imm` is 0.
- R5: When the result-write bit is clear, `wr_en` stays low even when the condition passes.
- R6: `z_upd` and `c_upd` are set independently. Each is high only when the condition passes and its own update bit is set, and only then does the matching flag change.
- R7: Every instruction holds `busy` for exactly four clocks and raises `commit` in the fourth. `instr_clocks` reads 4.
- R8: `wr_en`, `z_upd` and `c_upd` can be high only in the commit clock. Flags take their new values at the clock edge that ends that clock.
- R9: Opcode 0 is move (result = operand), 1 is add, 2 is subtract (destination minus operand), 3 is AND. Any other opcode behaves as move. The zero result is (result == 0). Carry is the carry out for add, the borrow for subtract, and 0 otherwise.
- R10: An issue offered while `busy` is high is ignored. The instruction in flight commits unchanged.
- R11: After reset, `busy`, `commit`, `wr_en`, `z_flag` and `c_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered this clock |
| issue_instr | input | 32 | Instruction word |
| dst_rdata | input | 32 | Destination register contents from datapath |
| src_rdata | input | 32 | Source register contents from datapath |
| busy | output | 1 | Instruction in flight |
| commit | output | 1 | Last clock of the instruction |
| cond_pass | output | 1 | Condition result of the instruction in flight |
| op_sel_imm | output | 1 | Operand select: 1 = immediate, 0 = register |
| dst_addr | output | 9 | Destination register address (read and write) |
| src_addr | output | 9 | Source register address |
| wr_en | output | 1 | Write result to destination |
| wr_data | output | 32 | Result value |
| z_upd | output | 1 | Zero flag updates this clock |
| c_upd | output | 1 | Carry flag updates this clock |
| z_flag | output | 1 | Current zero flag |
| c_flag | output | 1 | Current carry flag |
| instr_clocks | output | 3 | Clocks each instruction takes |

## Verification
An issue offered before rising edge E0 is accepted at E0. `busy` is high from E0 to E4, the commit outputs are valid in the clock after edge E3, and the flags change at E4. The bench drives and samples on falling edges. It checks `busy` without `commit` after E0, E1 and E2, checks all commit outputs after E3, and checks flags and idle after E4. The sweep covers every condition code, every flag state and every combination of the four control bits. The flags are set before each sweep step by instructions whose effects are known. One run pushes a second issue in mid-flight.

// File: rtl/cexec_pkg.sv
package cexec_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 6;
  localparam int COND_W = 4;
  localparam int ADDR_W = 9;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic              upd_z;
    logic              upd_c;
    logic              wr_res;
    logic              imm;
    logic [COND_W-1:0] cond;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
  } instr_t;

  typedef enum logic [OPC_W-1:0] {
    OP_MOV = 6'd0,
    OP_ADD = 6'd1,
    OP_SUB = 6'd2,
    OP_AND = 6'd3
  } op_e;
endpackage

// File: rtl/cexec_cond.sv
module cexec_cond
  import cexec_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic              z_in,
  input  logic              c_in,
  output logic              pass
);
  logic [1:0] sel;

  always_comb begin
    sel  = {c_in, z_in};
    pass = cond[sel];
  end

  // R2
  always_comb begin
    if (cond == '0) never_pass_chk: assert (!pass);
    if (cond == '1) always_pass_chk: assert (pass);
  end
endmodule

// File: rtl/cexec_alu.sv
module cexec_alu
  import cexec_pkg::*;
(
  input  logic [OPC_W-1:0]  opc,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] res,
  output logic              carry,
  output logic              zero
);
  logic [WORD_W:0] wide;

  always_comb begin
    wide  = '0;
    res   = b;
    carry = 1'b0;
    unique case (opc)
      OP_ADD: begin
        wide  = {1'b0, a} + {1'b0, b};
        res   = wide[WORD_W-1:0];
        carry = wide[WORD_W];
      end
      OP_SUB: begin
        wide  = {1'b0, a} - {1'b0, b};
        res   = wide[WORD_W-1:0];
        carry = wide[WORD_W];
      end
      OP_AND: res = a & b;
      default: res = b;
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/cexec_seq.sv
module cexec_seq #(
  parameter int CYCLES = 4,
  localparam int PH_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            last,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYCLES - 1);

  logic            busy_q, busy_d;
  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        phase_d = '0;
      end
    end else if (phase_q == LAST_PH) begin
      busy_d = 1'b0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
    end
  end

  assign busy  = busy_q;
  assign phase = phase_q;
  assign last  = busy_q && (phase_q == LAST_PH);

  // R7
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  // R7
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && phase == '0));
  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
endmodule

// File: rtl/cexec_ctrl.sv
module cexec_ctrl
  import cexec_pkg::*;
#(
  parameter int CYCLES = 4,
  localparam int CLK_W = $clog2(CYCLES + 1),
  localparam int PH_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [WORD_W-1:0] issue_instr,
  input  logic [WORD_W-1:0] dst_rdata,
  input  logic [WORD_W-1:0] src_rdata,
  output logic              busy,
  output logic              commit,
  output logic              cond_pass,
  output logic              op_sel_imm,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [ADDR_W-1:0] src_addr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              z_upd,
  output logic              c_upd,
  output logic              z_flag,
  output logic              c_flag,
  output logic [CLK_W-1:0]  instr_clocks
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic            accept;
  logic            last;
  logic [PH_W-1:0] phase;
  instr_t          ins_q, ins_d;
  logic            z_q, z_d, c_q, c_d;

  cexec_seq #(.CYCLES(CYCLES)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (issue_valid),
    .busy  (busy),
    .last  (last),
    .phase (phase)
  );

  assign accept = issue_valid && !busy;

  // instruction register: loaded only when idle
  always_comb begin
    ins_d = ins_q;
    if (accept) ins_d = instr_t'(issue_instr);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ins_q <= '0;
    else             ins_q <= ins_d;
  end

  // operand select
  logic [WORD_W-1:0] operand;
  always_comb begin
    op_sel_imm = ins_q.imm;
    operand    = ins_q.imm ? {{(WORD_W-ADDR_W){1'b0}}, ins_q.src} : src_rdata;
    dst_addr   = ins_q.dst;
    src_addr   = ins_q.src;
  end

  cexec_cond u_cond (
    .cond (ins_q.cond),
    .z_in (z_q),
    .c_in (c_q),
    .pass (cond_pass)
  );

  logic [WORD_W-1:0] alu_res;
  logic              alu_c, alu_z;

  cexec_alu u_alu (
    .opc   (ins_q.opc),
    .a     (dst_rdata),
    .b     (operand),
    .res   (alu_res),
    .carry (alu_c),
    .zero  (alu_z)
  );

  // commit enables: only in the last clock
  always_comb begin
    commit  = last;
    wr_en   = last && cond_pass && ins_q.wr_res;
    z_upd   = last && cond_pass && ins_q.upd_z;
    c_upd   = last && cond_pass && ins_q.upd_c;
    wr_data = alu_res;
  end

  always_comb begin
    z_d = z_q;
    c_d = c_q;
    if (z_upd) z_d = alu_z;
    if (c_upd) c_d = alu_c;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      z_q <= z_d;
      c_q <= c_d;
    end
  end

  assign z_flag       = z_q;
  assign c_flag       = c_q;
  assign instr_clocks = CLK_W'(CYCLES);

  // R8
  wr_in_last_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en || z_upd || c_upd) |-> commit);
  // R8
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !commit |=> (z_flag == $past(z_flag) && c_flag == $past(c_flag)));
  // R3
  skip_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && !cond_pass) |=> (z_flag == $past(z_flag) && c_flag == $past(c_flag)));
  // R10
  busy_ignores_issue_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && issue_valid) |=> (dst_addr == $past(dst_addr) && src_addr == $past(src_addr)));
  // R5
  no_wr_without_r_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !ins_q.wr_res) |-> !wr_en);
endmodule

// File: tb/cexec_ctrl_bench.sv
`timescale 1ns/1ps
module cexec_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] issue_instr, dst_rdata, src_rdata;
  logic        busy, commit, cond_pass, op_sel_imm, wr_en, z_upd, c_upd, z_flag, c_flag;
  logic [8:0]  dst_addr, src_addr;
  logic [31:0] wr_data;
  logic [2:0]  instr_clocks;

  int n_chk = 0;
  int n_bad = 0;
  logic mz, mc;

  always #2.5 clk = ~clk;

  cexec_ctrl u_cexec_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
    .dst_rdata(dst_rdata), .src_rdata(src_rdata), .busy(busy), .commit(commit),
    .cond_pass(cond_pass), .op_sel_imm(op_sel_imm), .dst_addr(dst_addr),
    .src_addr(src_addr), .wr_en(wr_en), .wr_data(wr_data), .z_upd(z_upd),
    .c_upd(c_upd), .z_flag(z_flag), .c_flag(c_flag), .instr_clocks(instr_clocks)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5ns * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  function automatic logic [31:0] mk(input logic [5:0] op, input logic zb, input logic cb,
                                     input logic rb, input logic ib, input logic [3:0] cond,
                                     input logic [8:0] dst, input logic [8:0] src);
    return {op, zb, cb, rb, ib, cond, dst, src};
  endfunction

  // one instruction, issued at a falling edge; optional second issue mid-flight
  task automatic run(input logic [31:0] ins, input logic [31:0] dv, input logic [31:0] sv,
                     input bit intrude);
    logic [5:0]  op;
    logic [31:0] b, res;
    logic [32:0] w;
    logic        pass, ec, ez;
    op   = ins[31:26];
    b    = ins[22] ? {23'b0, ins[8:0]} : sv;
    pass = ins[18 + {mc, mz}];
    w    = '0;
    case (op)
      6'd1: w = {1'b0, dv} + {1'b0, b};
      6'd2: w = {1'b0, dv} - {1'b0, b};
      6'd3: w = {1'b0, dv & b};
      default: w = {1'b0, b};
    endcase
    res = w[31:0];
    ec  = (op == 6'd1 || op == 6'd2) ? w[32] : 1'b0;
    ez  = (res == 0);

    issue_valid = 1'b1;
    issue_instr = ins;
    dst_rdata   = dv;
    src_rdata   = sv;
    @(negedge clk);
    if (intrude) begin
      issue_instr = ~ins;
    end else begin
      issue_valid = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      chk("R7 busy held", {31'b0, busy}, 32'd1);
      chk("R8 no commit early", {29'b0, commit, wr_en, z_upd | c_upd}, 32'd0);
      @(negedge clk);
      issue_valid = 1'b0;
    end
    chk("R7 commit in 4th clock", {31'b0, commit}, 32'd1);
    chk("R2 condition result", {31'b0, cond_pass}, {31'b0, pass});
    chk("R5 R3 write enable", {31'b0, wr_en}, {31'b0, pass & ins[23]});
    chk("R6 zero update enable", {31'b0, z_upd}, {31'b0, pass & ins[25]});
    chk("R6 carry update enable", {31'b0, c_upd}, {31'b0, pass & ins[24]});
    chk("R4 operand select", {31'b0, op_sel_imm}, {31'b0, ins[22]});
    chk("R1 destination field", {23'b0, dst_addr}, {23'b0, ins[17:9]});
    chk("R1 source field", {23'b0, src_addr}, {23'b0, ins[8:0]});
    chk("R9 R4 result", wr_data, res);
    if (pass && ins[25]) mz = ez;
    if (pass && ins[24]) mc = ec;
    @(negedge clk);
    chk("R7 idle after 4 clocks", {31'b0, busy}, 32'd0);
    chk("R6 R3 R8 zero flag", {31'b0, z_flag}, {31'b0, mz});
    chk("R6 R3 R8 carry flag", {31'b0, c_flag}, {31'b0, mc});
  endtask

  task automatic set_flags(input logic [1:0] cz);
    case (cz)
      2'd0: run(mk(6'd0, 1, 1, 0, 1, 4'hF, 9'd0, 9'd1), 32'd0, 32'd0, 0);
      2'd1: run(mk(6'd0, 1, 1, 0, 1, 4'hF, 9'd0, 9'd0), 32'd0, 32'd0, 0);
      2'd2: run(mk(6'd2, 1, 1, 0, 1, 4'hF, 9'd0, 9'd1), 32'd0, 32'd0, 0);
      default: run(mk(6'd1, 1, 1, 0, 1, 4'hF, 9'd0, 9'd1), 32'hFFFF_FFFF, 32'd0, 0);
    endcase
    chk("R9 flag setup", {30'b0, c_flag, z_flag}, {30'b0, cz});
  endtask

  initial begin
    logic [31:0] vals [4];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h1234_5678;
    rst_n = 1'b0;
    issue_valid = 1'b0;
    issue_instr = '0;
    dst_rdata = '0;
    src_rdata = '0;
    mz = 1'b0;
    mc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset busy", {31'b0, busy}, 32'd0);
    chk("R11 reset commit/write", {30'b0, commit, wr_en}, 32'd0);
    chk("R11 reset flags", {30'b0, z_flag, c_flag}, 32'd0);
    chk("R7 clock count", {29'b0, instr_clocks}, 32'd4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle after release", {31'b0, busy}, 32'd0);

    // sweep: every flag state x condition x control-bit combination
    for (int fl = 0; fl < 4; fl++) begin
      for (int cd = 0; cd < 16; cd++) begin
        for (int bits = 0; bits < 16; bits++) begin
          logic [3:0] c4, b4;
          c4 = 4'(cd);
          b4 = 4'(bits);
          set_flags(2'(fl));
          run(mk(6'((cd + bits) % 5), b4[3], b4[2], b4[1], b4[0], c4,
                 {2'(fl), c4, 3'(bits)}, {c4, b4, 1'b1}),
              vals[c4[1:0]], vals[b4[3:2]], 0);
        end
      end
    end

    // R10: second issue while busy is dropped
    set_flags(2'd0);
    run(mk(6'd1, 1, 1, 1, 0, 4'hF, 9'h0A5, 9'h05A), 32'd7, 32'd9, 1);
    chk("R10 no extra instruction", {31'b0, busy}, 32'd0);
    summary();
  end
endmodule